// File: doc/BRIEF.md
# Power-of-Two System Watchdog

This block is a system-level watchdog timer. It has no prescaler: it counts raw clock periods. The timeout length is never written as a cycle count. Software writes a small exponent code instead, and code `c` selects a period of `2^(BASE_EXP + c)` cycles.

Two codes are held:
- A start code sets the length of the very first countdown after the unit is enabled.
- A regular code sets every countdown after that.

Software drives the block through a simple word-wide register port. It uses this port to:
- arm the unit;
- pick the response style;
- restart ("kick") the countdown;
- clear the pending interrupt;
- read back the configuration, the interrupt flag and the live count.

Once armed, the unit keeps running until the block's own reset. There are two response styles:
- **Reset style.** Every expiry raises a one-cycle warm-reset request.
- **Interrupt-first style.** The first unanswered expiry raises an interrupt. The warm-reset request follows only if the interrupt is still pending at the next expiry.

Register map (write address `wr_addr`, read address `rd_addr`):

| Addr | Write | Read |
|------|-------|------|
| 0 | bit0 = 1 arms the unit; bit1 = response style (0 reset, 1 interrupt-first) | bit0 armed, bit1 style |
| 1 | bits[CODE_W-1:0] regular code, bits[2*CODE_W-1:CODE_W] start code | same fields |
| 2 | any data: kick | 0 |
| 3 | bit0 = 1 clears the interrupt | bit0 interrupt flag |
| 4 | none | live count |

Top module: `wdt_pow2`

## Requirements
- R1: After reset the unit is disarmed. It is in reset style, with both codes 0, a live count of 0, and `irq` and `wrst_req` low. Every readable register (addresses 0, 1, 3, 4) reads 0.
- R2: Code `c` gives a period of `2^(BASE_EXP+c)` cycles. The count loads `2^(BASE_EXP+c)-1` and drops by one on each clock while armed. Expiry happens on the edge where the count is already 0.
- R3: Writing address 0 with bit0 = 1 while disarmed arms the unit on that edge. That same edge loads the count from the start code (address 1, upper field). Every later reload uses the regular code (lower field).
- R4: Once armed, writing address 0 with bit0 = 0 does not disarm the unit. Only the block reset disarms it.
- R5: In reset style (address 0 bit1 = 0), each expiry drives `wrst_req` high for the single cycle after the expiry edge, and `irq` stays low.
- R6: In interrupt-first style (bit1 = 1), an expiry with no pending interrupt sets `irq` without a reset request. An expiry with `irq` still pending pulses `wrst_req`. Clearing the interrupt between expiries (write address 3 with bit0 = 1) makes the next expiry raise `irq` again instead of a reset request.
- R7: A kick (any write to address 2) while armed reloads the count from the regular code and clears `irq`. A kick on the edge where the count is 0 suppresses that expiry.
- R8: Writing new codes while armed leaves the running count untouched. The new regular code first applies at the next reload.
- R9: The register port reads back the armed bit and the style (address 0), both code fields (address 1), the interrupt flag (address 3) and the live count at full `CNT_W` width (address 4).
- R10: `wrst_req` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 2*CODE_W | Write data |
| rd_addr | input | 3 | Read address (combinational read) |
| rd_data | output | CNT_W = BASE_EXP+2^CODE_W | Read data |
| irq | output | 1 | Pending interrupt (level) |
| wrst_req | output | 1 | Warm-reset request (single-cycle pulse) |

## Verification
The bench builds the block with `BASE_EXP = 2` and keeps the default `CODE_W = 4`. The shortest period is therefore 4 cycles, and codes 0 to 3 give periods of 4 to 32 cycles. This makes the following reachable within a few dozen cycles each:
- the switch from start code to regular code;
- both escalation paths of interrupt-first style;
- a kick landing exactly on the zero-count edge;
- a code change taking effect only at the next reload.

The count width shrinks to 18 bits, but the exponent arithmetic and the full 16-code range are unchanged. Expiry events are predicted cycle by cycle and matched against the observed `irq` rises and `wrst_req` pulses.

// File: rtl/wdt_pow2_pkg.sv
package wdt_pow2_pkg;

  typedef enum logic {
    RESP_RESET     = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CODES = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_KICK  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_IRQ   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 3'd4;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pow2_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [2*CODE_W-1:0]   wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]      cnt_val,
  input  logic                  irq,
  output logic                  armed,
  output resp_mode_e            mode,
  output logic [CODE_W-1:0]     start_code,
  output logic [CODE_W-1:0]     run_code,
  output logic                  start_evt,
  output logic                  kick_evt,
  output logic                  clr_evt,
  output logic [CNT_W-1:0]      rd_data
);

  logic wr_ctrl;
  logic wr_codes;

  // Write decode: one-cycle event strobes.
  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    wr_codes  = wr_en && (wr_addr == ADDR_CODES);
    start_evt = wr_ctrl && wr_data[0] && !armed;
    kick_evt  = wr_en && (wr_addr == ADDR_KICK) && armed;
    clr_evt   = wr_en && (wr_addr == ADDR_IRQ) && wr_data[0];
  end

  // Configuration registers. The armed bit can only be set; only rst_n clears it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      mode       <= RESP_RESET;
      start_code <= '0;
      run_code   <= '0;
    end else begin
      if (start_evt) armed <= 1'b1;
      if (wr_ctrl)   mode  <= resp_mode_e'(wr_data[1]);
      if (wr_codes) begin
        run_code   <= wr_data[CODE_W-1:0];
        start_code <= wr_data[2*CODE_W-1:CODE_W];
      end
    end
  end

  // Read mux.
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[0] = armed;
        rd_data[1] = mode;
      end
      ADDR_CODES: rd_data[2*CODE_W-1:0] = {start_code, run_code};
      ADDR_IRQ:   rd_data[0]            = irq;
      ADDR_COUNT: rd_data               = cnt_val;
      default:    rd_data               = '0;
    endcase
  end

  // R4: once armed, the unit stays armed until block reset.
  p_armed_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R3: an arming write leaves the unit armed on the following cycle.
  p_arm_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data[0]) |=> armed);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              start_evt,
  input  logic              kick_evt,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] run_code,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              expire_evt
);

  // Load value for a code: one less than 2^(BASE_EXP + code).
  function automatic logic [CNT_W-1:0] reload_of(input logic [CODE_W-1:0] code);
    int unsigned shamt;
    shamt = BASE_EXP + int'(code);
    return (CNT_W'(1) << shamt) - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] start_load;
  logic [CNT_W-1:0] run_load;

  always_comb begin
    start_load = reload_of(start_code);
    run_load   = reload_of(run_code);
    // A kick on the zero-count edge wins over the expiry.
    expire_evt = armed && (cnt_val == '0) && !kick_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_val <= '0;
    end else if (start_evt) begin
      cnt_val <= start_load;
    end else if (kick_evt || expire_evt) begin
      cnt_val <= run_load;
    end else if (armed) begin
      cnt_val <= cnt_val - CNT_W'(1);
    end
  end

  // R2: a running, unkicked, nonzero count drops by exactly one.
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !kick_evt && cnt_val != '0) |=> cnt_val == $past(cnt_val) - CNT_W'(1));

  // R2: an expiry reloads to a nonzero value.
  p_wrap_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> cnt_val != '0);

  // R1: while disarmed and not starting, the count does not move.
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_evt) |=> $stable(cnt_val));

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pow2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  resp_mode_e mode,
  input  logic       expire_evt,
  input  logic       kick_evt,
  input  logic       clr_evt,
  output logic       irq,
  output logic       wrst_req
);

  logic first_warn;
  logic escalate;

  always_comb begin
    first_warn = expire_evt && (mode == RESP_IRQ_FIRST) && !irq;
    escalate   = expire_evt && ((mode == RESP_RESET) || irq);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      wrst_req <= 1'b0;
    end else begin
      wrst_req <= escalate;
      if (first_warn)              irq <= 1'b1;
      else if (kick_evt || clr_evt) irq <= 1'b0;
    end
  end

  // R5: in reset style, an expiry yields a reset request on the next cycle.
  p_reset_style_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode == RESP_RESET) |=> wrst_req);

  // R6: the first unanswered expiry in interrupt-first style only warns.
  p_first_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode == RESP_IRQ_FIRST && !irq) |=> (irq && !wrst_req));

  // R6: a second expiry with the warning still pending escalates.
  p_escalate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && irq) |=> wrst_req);

  // R7: a kick always leaves the interrupt cleared.
  p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> !irq);

  // R10: the reset request is a single-cycle pulse.
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_req |=> !wrst_req);

endmodule

// File: rtl/wdt_pow2.sv
module wdt_pow2
  import wdt_pow2_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CODE_W   = 4,
  localparam int unsigned CNT_W   = BASE_EXP + (1 << CODE_W),
  localparam int unsigned WR_W    = 2 * CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]       wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]      rd_data,
  output logic                  irq,
  output logic                  wrst_req
);

  // Internal events brought out by name.
  logic              armed;
  resp_mode_e        mode;
  logic [CODE_W-1:0] start_code;
  logic [CODE_W-1:0] run_code;
  logic              start_evt;
  logic              kick_evt;
  logic              clr_evt;
  logic              expire_evt;
  logic [CNT_W-1:0]  cnt_val;

  wdt_regs #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .cnt_val    (cnt_val),
    .irq        (irq),
    .armed      (armed),
    .mode       (mode),
    .start_code (start_code),
    .run_code   (run_code),
    .start_evt  (start_evt),
    .kick_evt   (kick_evt),
    .clr_evt    (clr_evt),
    .rd_data    (rd_data)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed),
    .start_evt  (start_evt),
    .kick_evt   (kick_evt),
    .start_code (start_code),
    .run_code   (run_code),
    .cnt_val    (cnt_val),
    .expire_evt (expire_evt)
  );

  wdt_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .expire_evt (expire_evt),
    .kick_evt   (kick_evt),
    .clr_evt    (clr_evt),
    .irq        (irq),
    .wrst_req   (wrst_req)
  );

  // R3: the arming edge loads a nonzero count, so no expiry on the next edge.
  p_start_no_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !expire_evt);

  // R7: kick and expiry never coincide.
  p_kick_vs_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(kick_evt && expire_evt));

endmodule

// File: tb/wdt_pow2_tb.sv
module wdt_pow2_tb;
  import wdt_pow2_pkg::*;

  localparam int unsigned BASE_EXP = 2;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CNT_W    = BASE_EXP + (1 << CODE_W);
  localparam int unsigned WR_W     = 2 * CODE_W;
  localparam int unsigned EV_IRQ   = 0;
  localparam int unsigned EV_RST   = 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic [REG_ADDR_W-1:0] wr_addr = '0;
  logic [WR_W-1:0]       wr_data = '0;
  logic [REG_ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]      rd_data;
  logic                  irq;
  logic                  wrst_req;

  wdt_pow2 #(.BASE_EXP(BASE_EXP), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .wrst_req(wrst_req)
  );

  always #10 clk = ~clk;  // 50 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    int unsigned kind;
    int unsigned at;
    string       req;
  } ev_t;
  ev_t exp_q[$];

  function automatic longint span(input int unsigned code);
    return longint'(1) << (BASE_EXP + code);
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_ev(input int unsigned kind, input int unsigned at, input string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compare every observed event against the scoreboard queue.
  logic irq_prev = 1'b0;
  task automatic observe(input int unsigned kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(kind == EV_RST ? "R5/R6/R10" : "R6", "unexpected event kind",
            longint'(kind), -1);
    end else begin
      e = exp_q.pop_front();
      check(e.req, "event kind", longint'(kind), longint'(e.kind));
      check(e.req, "event cycle", longint'(cyc), longint'(e.at));
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      irq_prev = 1'b0;
    end else begin
      if (wrst_req) observe(EV_RST);
      if (irq && !irq_prev) observe(EV_IRQ);
      irq_prev = irq;
    end
  end

  task automatic wait_until(input int unsigned x);
    while (cyc < x) @(negedge clk);
  endtask

  task automatic wr_at(input int unsigned x, input logic [REG_ADDR_W-1:0] a,
                       input logic [WR_W-1:0] d);
    wait_until(x - 1);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int unsigned x, input logic [REG_ADDR_W-1:0] a,
                        input longint expv, input string req, input string what);
    wait_until(x);
    rd_addr = a;
    #1;
    check(req, what, longint'(rd_data), expv);
  endtask

  task automatic drain(input string req);
    check(req, "pending expected events", longint'(exp_q.size()), 0);
    exp_q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [WR_W-1:0] codes(input int unsigned st, input int unsigned rg);
    return WR_W'((st << CODE_W) | rg);
  endfunction

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned e;

    // R1: reset state
    do_reset();
    check("R1", "irq after reset", longint'(irq), 0);
    check("R1", "wrst_req after reset", longint'(wrst_req), 0);
    rd_chk(cyc, ADDR_CTRL, 0, "R1", "ctrl");
    rd_chk(cyc, ADDR_CODES, 0, "R1", "codes");
    rd_chk(cyc, ADDR_COUNT, 0, "R1", "count");
    rd_chk(cyc, ADDR_IRQ, 0, "R1", "irq flag");

    // R2 R3 R4 R5: reset style, start code 1, regular code 0
    do_reset();
    e = cyc + 3;
    wr_at(e - 1, ADDR_CODES, codes(1, 0));
    wr_at(e, ADDR_CTRL, 1);
    push_ev(EV_RST, e + 8, "R3");
    push_ev(EV_RST, e + 12, "R5");
    push_ev(EV_RST, e + 16, "R5");
    push_ev(EV_RST, e + 20, "R4");
    push_ev(EV_RST, e + 24, "R4");
    rd_chk(e, ADDR_COUNT, span(1) - 1, "R3", "count at arm");
    rd_chk(e, ADDR_CODES, 64'd16, "R9", "codes readback");
    rd_chk(e + 3, ADDR_COUNT, span(1) - 4, "R2", "count after 3 clocks");
    rd_chk(e + 8, ADDR_COUNT, span(0) - 1, "R3", "reload uses regular code");
    wr_at(e + 17, ADDR_CTRL, 0);
    rd_chk(e + 18, ADDR_CTRL, 1, "R4", "armed bit after disarm attempt");
    rd_chk(e + 18, ADDR_IRQ, 0, "R5", "irq stays low in reset style");
    wait_until(e + 26);
    drain("R4");

    // R6: interrupt-first escalation without a clear
    do_reset();
    e = cyc + 3;
    wr_at(e - 1, ADDR_CODES, codes(0, 1));
    wr_at(e, ADDR_CTRL, 3);
    push_ev(EV_IRQ, e + 4, "R6");
    push_ev(EV_RST, e + 12, "R6");
    push_ev(EV_RST, e + 20, "R6");
    rd_chk(e, ADDR_CTRL, 3, "R9", "ctrl readback");
    rd_chk(e + 4, ADDR_IRQ, 1, "R6", "irq after first expiry");
    rd_chk(e + 13, ADDR_IRQ, 1, "R6", "irq still pending after escalation");
    wait_until(e + 21);
    drain("R6");

    // R6 R7: clear between expiries, then kick clears irq
    do_reset();
    e = cyc + 3;
    wr_at(e - 1, ADDR_CODES, codes(0, 1));
    wr_at(e, ADDR_CTRL, 3);
    push_ev(EV_IRQ, e + 4, "R6");
    wr_at(e + 6, ADDR_IRQ, 1);
    rd_chk(e + 7, ADDR_IRQ, 0, "R6", "irq after clear");
    push_ev(EV_IRQ, e + 12, "R6");
    wr_at(e + 14, ADDR_KICK, 0);
    rd_chk(e + 15, ADDR_IRQ, 0, "R7", "irq after kick");
    rd_chk(e + 15, ADDR_COUNT, span(1) - 2, "R7", "count after kick");
    push_ev(EV_IRQ, e + 22, "R7");
    wait_until(e + 23);
    drain("R7");

    // R7: kick mid-count and on the zero-count edge
    do_reset();
    e = cyc + 3;
    wr_at(e - 1, ADDR_CODES, codes(2, 0));
    wr_at(e, ADDR_CTRL, 1);
    wr_at(e + 5, ADDR_KICK, 0);
    rd_chk(e + 5, ADDR_COUNT, span(0) - 1, "R7", "count after kick");
    push_ev(EV_RST, e + 9, "R7");
    wr_at(e + 13, ADDR_KICK, 0);
    rd_chk(e + 13, ADDR_COUNT, span(0) - 1, "R7", "count after zero-edge kick");
    push_ev(EV_RST, e + 17, "R7");
    wait_until(e + 18);
    drain("R7");

    // R8: code change while running
    do_reset();
    e = cyc + 3;
    wr_at(e - 1, ADDR_CODES, codes(0, 0));
    wr_at(e, ADDR_CTRL, 1);
    wr_at(e + 1, ADDR_CODES, codes(3, 2));
    rd_chk(e + 1, ADDR_COUNT, span(0) - 2, "R8", "count unaffected by code write");
    push_ev(EV_RST, e + 4, "R8");
    push_ev(EV_RST, e + 20, "R8");
    rd_chk(e + 5, ADDR_COUNT, span(2) - 2, "R8", "new regular code after reload");
    wait_until(e + 21);
    drain("R8");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule